// File: doc/BRIEF.md
# Vector Float Data Class Tester

This block looks at a 128-bit vector that holds four single-precision floating-point lanes. It sorts each lane into one of five categories: NaN, infinity, zero, subnormal or normal. It then checks that category and the lane's sign against a 7-bit selection mask. Every lane that matches a selected category and sign gets an all-ones 32-bit word in the same lane of the result. Every other lane gets zero. A vector unit uses the result directly as a per-lane predicate, for example to pick out NaNs or signed zeros before a blend.

Each accepted request produces one registered result one clock later. An enable input says whether the vector extension is switched on. If a request arrives while it is off, the block flags an unavailable fault in place of a result and drives zero data. Whatever handles the trap does so outside this block.

Top module: `vec_fclass_tester`

## Requirements
- R1: Lane k (k = 0..3) of `src_vec` occupies bits [127-32k : 96-32k], so lane 0 is bits 127:96 and lane 3 is bits 31:0. Within a lane, bit 31 is the sign, bits 30:23 are the exponent and bits 22:0 are the fraction. The result lane uses the same position in `out_vec` as its source lane.
- R2: A lane whose exponent is all ones and whose fraction is nonzero is a NaN. It matches when `class_mask[6]` is set, whatever its sign.
- R3: A lane whose exponent is all ones and whose fraction is zero is an infinity. It matches through `class_mask[5]` when positive and through `class_mask[4]` when negative.
- R4: A lane whose exponent and fraction are both zero is a zero. It matches through `class_mask[3]` when positive and through `class_mask[2]` when negative.
- R5: A lane whose exponent is zero and whose fraction is nonzero is a subnormal. It matches through `class_mask[1]` when positive and through `class_mask[0]` when negative.
- R6: A normal finite lane never matches under any mask, so its result lane is zero.
- R7: Each result lane is either 0xFFFFFFFF (match) or 0x00000000 (no match). Nothing else can appear.
- R8: When `in_valid` is high and `ext_enable` is high at a clock edge, `out_valid` is high for exactly the next cycle and `out_vec` carries the result for that request.
- R9: When `in_valid` is high and `ext_enable` is low, `out_fault` is high in the next cycle, while `out_valid` stays low and `out_vec` is zero.
- R10: While `rst_n` is low at a clock edge (synchronous, active low), `out_valid`, `out_fault` and `out_vec` are cleared in the next cycle, even if a request is presented at the same time.
- R11: `out_vec` is zero in every cycle in which `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A request is present this cycle |
| ext_enable | input | 1 | Vector extension switched on |
| src_vec | input | 128 | Four single-precision source lanes |
| class_mask | input | 7 | Category and sign selection mask |
| out_valid | output | 1 | Result is valid this cycle |
| out_fault | output | 1 | Unavailable fault for the previous request |
| out_vec | output | 128 | Per-lane all-ones or all-zeros result |

## Verification
Every output of this block, whether a result, a fault or a reset clear, is due exactly one rising edge after the inputs that caused it. The bench drives a new request at every falling edge and pushes one expected item for each cycle it drives, including idle, fault and reset cycles. The monitor pops one item shortly after each rising edge and compares it against `out_valid`, `out_fault` and `out_vec` together. The queue order therefore ties each observation to the single cycle in which it must appear.

// File: rtl/vfc_pkg.sv
// Package: vfc_pkg
// Shared field widths, mask bit positions and the category type used by the
// vector float data class tester. Assumes IEEE single-precision lane layout.
package vfc_pkg;
    localparam int LANE_W = 32;
    localparam int EXP_W  = 8;
    localparam int FRAC_W = LANE_W - 1 - EXP_W;
    localparam int MASK_W = 7;

    // Mask bit positions; the selection order is part of the interface.
    localparam int MB_NAN   = 6;
    localparam int MB_PINF  = 5;
    localparam int MB_NINF  = 4;
    localparam int MB_PZERO = 3;
    localparam int MB_NZERO = 2;
    localparam int MB_PSUB  = 1;
    localparam int MB_NSUB  = 0;

    typedef enum logic [2:0] {
        FC_NORMAL = 3'd0,
        FC_ZERO   = 3'd1,
        FC_SUB    = 3'd2,
        FC_INF    = 3'd3,
        FC_NAN    = 3'd4
    } fclass_e;
endpackage

// File: rtl/vfc_lane_classify.sv
// Module: vfc_lane_classify
// Splits one single-precision word into sign, exponent and fraction and
// reports its category. Purely combinational; assumes sign at the MSB.
module vfc_lane_classify
    import vfc_pkg::*;
(
    input  logic [LANE_W-1:0] lane_i,
    output fclass_e           cls_o,
    output logic              neg_o
);
    localparam int EXP_LSB = FRAC_W;
    localparam int EXP_MSB = FRAC_W + EXP_W - 1;

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_max;
    logic              exp_min;
    logic              frac_nz;

    // Field extraction and range flags.
    always_comb begin
        exp_f   = lane_i[EXP_MSB:EXP_LSB];
        frac_f  = lane_i[FRAC_W-1:0];
        exp_max = &exp_f;
        exp_min = ~|exp_f;
        frac_nz = |frac_f;
        neg_o   = lane_i[LANE_W-1];
    end

    // Category decision from the exponent extremes and fraction.
    always_comb begin
        if (exp_max)      cls_o = frac_nz ? FC_NAN : FC_INF;
        else if (exp_min) cls_o = frac_nz ? FC_SUB : FC_ZERO;
        else              cls_o = FC_NORMAL;
    end
endmodule

// File: rtl/vfc_lane_match.sv
// Module: vfc_lane_match
// Tests a lane's category and sign against the selection mask. NaN ignores
// the sign; normal values never match. Purely combinational.
module vfc_lane_match
    import vfc_pkg::*;
(
    input  fclass_e           cls_i,
    input  logic              neg_i,
    input  logic [MASK_W-1:0] mask_i,
    output logic              hit_o
);
    // Select the mask bit that governs this category and sign.
    always_comb begin
        unique case (cls_i)
            FC_NAN:  hit_o = mask_i[MB_NAN];
            FC_INF:  hit_o = neg_i ? mask_i[MB_NINF]  : mask_i[MB_PINF];
            FC_ZERO: hit_o = neg_i ? mask_i[MB_NZERO] : mask_i[MB_PZERO];
            FC_SUB:  hit_o = neg_i ? mask_i[MB_NSUB]  : mask_i[MB_PSUB];
            default: hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/vec_fclass_tester.sv
// Module: vec_fclass_tester
// Top level: classifies each lane of a vector, expands each match into a
// full-width lane mask and registers the result, or flags a fault when the
// vector extension is off. Lane 0 sits at the most significant end.
module vec_fclass_tester
    import vfc_pkg::*;
#(
    parameter int NUM_LANES = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic                          ext_enable,
    input  logic [NUM_LANES*LANE_W-1:0]   src_vec,
    input  logic [MASK_W-1:0]             class_mask,
    output logic                          out_valid,
    output logic                          out_fault,
    output logic [NUM_LANES*LANE_W-1:0]   out_vec
);
    localparam int VEC_W = NUM_LANES * LANE_W;

    fclass_e                  lane_cls [NUM_LANES];
    logic [NUM_LANES-1:0]     lane_neg;
    logic [NUM_LANES-1:0]     lane_hit;
    logic [VEC_W-1:0]         res_vec;
    logic                     accept;
    logic                     refuse;

    for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
        localparam int HI = VEC_W - 1 - k*LANE_W;
        localparam int LO = VEC_W - (k+1)*LANE_W;

        vfc_lane_classify u_cls (
            .lane_i (src_vec[HI:LO]),
            .cls_o  (lane_cls[k]),
            .neg_o  (lane_neg[k])
        );

        vfc_lane_match u_match (
            .cls_i  (lane_cls[k]),
            .neg_i  (lane_neg[k]),
            .mask_i (class_mask),
            .hit_o  (lane_hit[k])
        );

        // Widen the lane hit to a full lane of ones or zeros.
        assign res_vec[HI:LO] = {LANE_W{lane_hit[k]}};

        AST_NORMAL_NEVER_HITS: assert property (@(posedge clk) disable iff (!rst_n)
            (lane_cls[k] == FC_NORMAL) |-> !lane_hit[k]); // R6
        AST_LANE_SOLID: assert property (@(posedge clk) disable iff (!rst_n)
            (out_vec[HI:LO] == '0) || (out_vec[HI:LO] == '1)); // R7
    end

    // Request acceptance versus refusal on the extension enable.
    always_comb begin
        accept = in_valid &&  ext_enable;
        refuse = in_valid && !ext_enable;
    end

    // Single result stage with synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_fault <= 1'b0;
            out_vec   <= '0;
        end else begin
            out_valid <= accept;
            out_fault <= refuse;
            out_vec   <= accept ? res_vec : '0;
        end
    end

    AST_RESULT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ext_enable) |=> out_valid); // R8
    AST_FAULT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !ext_enable) |=> (out_fault && !out_valid && out_vec == '0)); // R9
    AST_NO_BOTH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_fault)); // R9
    AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_vec == '0)); // R11
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_fault && out_vec == '0)); // R10
endmodule

// File: tb/vec_fclass_tester_tb_top.sv
// Scoreboard bench: the driver pushes one expected item per driven cycle,
// the monitor pops one item just after every rising edge and compares.
module vec_fclass_tester_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct {
        logic         v;
        logic         f;
        logic [127:0] d;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         ext_enable = 1'b0;
    logic [127:0] src_vec = '0;
    logic [6:0]   class_mask = '0;
    logic         out_valid;
    logic         out_fault;
    logic [127:0] out_vec;

    exp_t sb_q[$];
    exp_t mon_item;
    int   n_checks = 0;
    int   n_fail   = 0;
    int   cycles   = 0;
    bit   done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vec_fclass_tester dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .ext_enable (ext_enable),
        .src_vec    (src_vec),
        .class_mask (class_mask),
        .out_valid  (out_valid),
        .out_fault  (out_fault),
        .out_vec    (out_vec)
    );

    // Reference rule for one lane, written from the requirements.
    function automatic logic lane_ref(input logic [31:0] w, input logic [6:0] m);
        logic       s;
        logic [7:0] e;
        logic       fz;
        s  = w[31];
        e  = w[30:23];
        fz = (w[22:0] == 23'd0);
        if (e == 8'hFF && !fz) return m[6];
        if (e == 8'hFF)        return s ? m[4] : m[5];
        if (e == 8'h00 && fz)  return s ? m[2] : m[3];
        if (e == 8'h00)        return s ? m[0] : m[1];
        return 1'b0;
    endfunction

    function automatic logic [127:0] vec_ref(input logic [127:0] v, input logic [6:0] m);
        logic [127:0] r;
        for (int k = 0; k < 4; k++)
            r[127-32*k -: 32] = {32{lane_ref(v[127-32*k -: 32], m)}};
        return r;
    endfunction

    task automatic drive(input logic rst_v, input logic vld, input logic en,
                         input logic [127:0] d, input logic [6:0] m, input string tag);
        exp_t e;
        @(negedge clk);
        rst_n      = rst_v;
        in_valid   = vld;
        ext_enable = en;
        src_vec    = d;
        class_mask = m;
        e.v   = rst_v && vld && en;
        e.f   = rst_v && vld && !en;
        e.d   = e.v ? vec_ref(d, m) : 128'd0;
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: compare the item due at this edge once outputs have settled.
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            mon_item = sb_q.pop_front();
            n_checks++;
            if (out_valid !== mon_item.v || out_fault !== mon_item.f || out_vec !== mon_item.d) begin
                n_fail++;
                $display("FAIL %s: actual v=%b f=%b d=%h expected v=%b f=%b d=%h",
                         mon_item.tag, out_valid, out_fault, out_vec,
                         mon_item.v, mon_item.f, mon_item.d);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            n_fail++;
            $display("FAIL watchdog: actual cycles=%0d expected below %0d", cycles, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0]  sp [12];
        logic [31:0]  lf;
        logic [127:0] v;
        logic [6:0]   m;
        sp[0]  = 32'h7FC00000; // +NaN
        sp[1]  = 32'hFFC00001; // -NaN
        sp[2]  = 32'h7F800000; // +inf
        sp[3]  = 32'hFF800000; // -inf
        sp[4]  = 32'h00000000; // +0
        sp[5]  = 32'h80000000; // -0
        sp[6]  = 32'h00000001; // +sub
        sp[7]  = 32'h807FFFFF; // -sub
        sp[8]  = 32'h3F800000; // normal
        sp[9]  = 32'hC0000000; // -normal
        sp[10] = 32'h7F7FFFFF; // max normal
        sp[11] = 32'h00800000; // min normal

        // R10: reset state, with a request offered during reset.
        drive(1'b0, 1'b1, 1'b1, {4{sp[0]}}, 7'h7F, "R10 reset");
        drive(1'b0, 1'b0, 1'b0, '0, '0, "R10 reset hold");

        // R2 R3 R4 R5: each single mask bit against groups of specials.
        for (int b = 0; b < 7; b++) begin
            drive(1'b1, 1'b1, 1'b1, {sp[0], sp[1], sp[2], sp[3]}, 7'(1 << b), "R2 R3 nan/inf");
            drive(1'b1, 1'b1, 1'b1, {sp[4], sp[5], sp[6], sp[7]}, 7'(1 << b), "R4 R5 zero/sub");
        end
        // R1: lane positions with a distinct pattern per lane.
        drive(1'b1, 1'b1, 1'b1, {sp[2], sp[8], sp[5], sp[9]}, 7'h20, "R1 lane0 only");
        drive(1'b1, 1'b1, 1'b1, {sp[8], sp[9], sp[10], sp[7]}, 7'h01, "R1 lane3 only");
        // R6: normals under a full mask.
        drive(1'b1, 1'b1, 1'b1, {sp[8], sp[9], sp[10], sp[11]}, 7'h7F, "R6 normals");
        // R7: full mask and empty mask on specials.
        drive(1'b1, 1'b1, 1'b1, {sp[1], sp[3], sp[5], sp[7]}, 7'h7F, "R7 all ones");
        drive(1'b1, 1'b1, 1'b1, {sp[1], sp[3], sp[5], sp[7]}, 7'h00, "R7 all zeros");
        // R9: fault, then back-to-back result after fault.
        drive(1'b1, 1'b1, 1'b0, {4{sp[0]}}, 7'h7F, "R9 fault");
        drive(1'b1, 1'b1, 1'b1, {4{sp[0]}}, 7'h40, "R8 after fault");
        // R11: idle cycle with live data on the inputs.
        drive(1'b1, 1'b0, 1'b1, {4{sp[2]}}, 7'h7F, "R11 idle");
        // R10: reset in the middle of traffic.
        drive(1'b1, 1'b1, 1'b1, {4{sp[4]}}, 7'h08, "R8 before reset");
        drive(1'b0, 1'b1, 1'b1, {4{sp[4]}}, 7'h08, "R10 mid reset");
        // R8: pseudo-random back-to-back traffic.
        lf = 32'hACE1_2357;
        for (int n = 0; n < 300; n++) begin
            for (int k = 0; k < 4; k++) begin
                lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
                v[127-32*k -: 32] = (lf[3:0] < 12) ? (sp[lf[3:0]] ^ {9'd0, lf[26:4]} & {9'd0, {23{lf[27]}}}) : lf;
            end
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            m = lf[6:0];
            drive(1'b1, lf[8] | lf[9], lf[10] | lf[11] | lf[12], v, m, "R8 random");
        end
        drive(1'b1, 1'b0, 1'b0, '0, '0, "R11 drain");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule